// File: doc/BRIEF.md
# Core-side Pin Control Unit

This unit sits beside a small processor core and owns 64 bidirectional pins, split into two 32-pin banks. For every pin it keeps an output-enable bit and an output-value bit. The core changes these bits in two ways. It can issue single-pin commands, each of which picks a pin, a command family and a value source. It can also overwrite a whole 32-bit bank register in one write. Register changes reach the pads through a fixed three-stage pipeline. The pad drives its value only while its enable bit is set.

Pad inputs pass through a synchronizer chain that has two read taps. A whole-bank word read sees samples that are three registers deep. A single-pin test sees samples that are two registers deep, so it is one clock fresher. The test returns new carry and zero flag values: it can write its tested bit into one of the flags, or combine the bit into that flag by AND, OR or XOR. The core supplies its current flags, latches the returned ones, and decodes its own instructions into these ports.

Top module: `gpio_pin_unit`

## Requirements
- R1: After reset every enable bit and every output bit is 0. padOe, padOut and rdData all read 0 until a command arrives or the pads change.
- R2: A 6-bit pin index addresses a pin. Bit 5 selects the bank and bits 4:0 select the bit inside the bank. Pad vector bit n is pin n, bank 0 holds pins 0–31, and bank 1 holds pins 32–63.
- R3: cmdFamily chooses what a single-pin command writes. 0 writes only the enable bit. 1 writes only the output bit. 2 writes the output bit and clears the enable bit. 3 writes the output bit and sets the enable bit.
- R4: cmdSrc chooses the value written. 0 gives 0, 1 gives 1, 2 gives flagC, 3 gives !flagC, 4 gives flagZ, 5 gives !flagZ, 6 gives a pseudo-random bit, and 7 gives the inverse of the target bit's current value. The target bit is the enable bit for family 0 and the output bit for the other families.
- R5: The random source changes every clock. Over 64 commands spaced a few clocks apart it yields both 0 and 1.
- R6: A register change made at clock edge E appears on padOe and padOut right after edge E+3, and not before that.
- R7: padOut[n] is 0 while padOe[n] is 0. A stored output value is driven once its enable bit is set.
- R8: A pad level applied before edge E is seen on rdData (the bank picked by rdBank) right after edge E+2, and not before that.
- R9: The same level is seen by the single-pin test right after edge E+1, one clock ahead of the word read.
- R10: With testValid high, testOp[0] picks the flag (0 = carry, 1 = zero) and testOp[2:1] picks the operation (0 write, 1 AND, 2 OR, 3 XOR). The tested bit is the sampled pad bit XOR testInvert. The other flag passes through unchanged. With testValid low, both flags pass through unchanged.
- R11: A word write loads wordWrData into the enable bank (wordWrSel = 0) or the output bank (wordWrSel = 1) chosen by wordWrBank. It has the same latency as R6.
- R12: When a word write and a single-pin command hit the same register in one cycle, the command's bit wins and the word supplies all the other bits.
- R13: A single-pin command with no word write changes at most one bit of each register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Single-pin command strobe |
| cmdFamily | input | 2 | Command family (R3) |
| cmdSrc | input | 3 | Value source (R4) |
| cmdPin | input | 6 | Target pin index |
| flagC | input | 1 | Core carry flag |
| flagZ | input | 1 | Core zero flag |
| wordWrValid | input | 1 | Word write strobe |
| wordWrSel | input | 1 | 0 = enable bank, 1 = output bank |
| wordWrBank | input | 1 | Bank chosen by the word write |
| wordWrData | input | 32 | Word write data |
| rdBank | input | 1 | Bank chosen for the word read |
| rdData | output | 32 | Synchronized input word |
| testValid | input | 1 | Single-pin test strobe |
| testPin | input | 6 | Pin to test |
| testInvert | input | 1 | Test the complement of the pin |
| testOp | input | 3 | Flag and operation for the test result |
| testCarryOut | output | 1 | Resulting carry flag |
| testZeroOut | output | 1 | Resulting zero flag |
| padIn | input | 64 | Pad input levels |
| padOe | output | 64 | Pad drive enables |
| padOut | output | 64 | Pad output levels |

## Verification
The hardest case to reach is the same-cycle collision between a word write and a single-pin command on the same register. Only a clock-aligned drive of both strobes together produces it. The bench drives both in one negative-edge slot and then compares the full 64-bit pad vectors, so a lost word bit or a lost command bit each shows up. The two input taps are reached by changing padIn once and sampling the test flags and rdData at each clock that follows. This separates the two-deep tap from the three-deep tap. Every output latency check also samples one clock early, to catch a stage that was skipped.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int NUM_PINS  = BANK_W * NUM_BANKS;
  localparam int IDX_W     = $clog2(NUM_PINS);
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  typedef enum logic [1:0] {FAM_DIR = 2'd0, FAM_OUT = 2'd1, FAM_FLT = 2'd2, FAM_DRV = 2'd3} famE;
  typedef enum logic [2:0] {
    SRC_LO = 3'd0, SRC_HI = 3'd1, SRC_C = 3'd2, SRC_NC = 3'd3,
    SRC_Z = 3'd4, SRC_NZ = 3'd5, SRC_RND = 3'd6, SRC_NOT = 3'd7
  } srcE;

  typedef struct packed {
    logic             setEn;
    logic             setOut;
    logic             enVal;
    logic             outVal;
    logic [IDX_W-1:0] pin;
  } pinStrobeT;
endpackage

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter logic [31:0] LFSR_SEED = 32'h1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdFamily,
  input  logic [2:0]       cmdSrc,
  input  logic [IDX_W-1:0] cmdPin,
  input  logic             flagC,
  input  logic             flagZ,
  input  logic             curEn,
  input  logic             curOut,
  input  logic             testValid,
  input  logic [2:0]       testOp,
  input  logic             testInvert,
  input  logic             testBit,
  output pinStrobeT        strobe,
  output logic             testCarryOut,
  output logic             testZeroOut
);
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  logic [31:0] lfsr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else       lfsr <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? LFSR_TAPS : 32'h0);
  end

  famE  fam;
  srcE  src;
  logic curBit;
  logic srcVal;

  always_comb begin
    fam    = famE'(cmdFamily);
    src    = srcE'(cmdSrc);
    curBit = (fam == FAM_DIR) ? curEn : curOut;
    unique case (src)
      SRC_LO:  srcVal = 1'b0;
      SRC_HI:  srcVal = 1'b1;
      SRC_C:   srcVal = flagC;
      SRC_NC:  srcVal = ~flagC;
      SRC_Z:   srcVal = flagZ;
      SRC_NZ:  srcVal = ~flagZ;
      SRC_RND: srcVal = lfsr[0];
      default: srcVal = ~curBit;
    endcase
  end

  always_comb begin
    strobe     = '0;
    strobe.pin = cmdPin;
    if (cmdValid) begin
      unique case (fam)
        FAM_DIR: begin strobe.setEn = 1'b1; strobe.enVal = srcVal; end
        FAM_OUT: begin strobe.setOut = 1'b1; strobe.outVal = srcVal; end
        FAM_FLT: begin
          strobe.setOut = 1'b1; strobe.outVal = srcVal;
          strobe.setEn  = 1'b1; strobe.enVal  = 1'b0;
        end
        default: begin
          strobe.setOut = 1'b1; strobe.outVal = srcVal;
          strobe.setEn  = 1'b1; strobe.enVal  = 1'b1;
        end
      endcase
    end
  end

  logic probe;
  logic flagIn;
  logic flagRes;
  always_comb begin
    probe  = testBit ^ testInvert;
    flagIn = testOp[0] ? flagZ : flagC;
    unique case (testOp[2:1])
      2'd0:    flagRes = probe;
      2'd1:    flagRes = flagIn & probe;
      2'd2:    flagRes = flagIn | probe;
      default: flagRes = flagIn ^ probe;
    endcase
    testCarryOut = (testValid && !testOp[0]) ? flagRes : flagC;
    testZeroOut  = (testValid &&  testOp[0]) ? flagRes : flagZ;
  end
endmodule

// File: rtl/gpio_pin_dp.sv
module gpio_pin_dp
  import gpio_pin_pkg::*;
#(
  parameter int OUT_STAGES     = 3,
  parameter int WORD_IN_STAGES = 3,
  parameter int TEST_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  pinStrobeT           strobe,
  input  logic [IDX_W-1:0]    cmdPin,
  input  logic                wordWrValid,
  input  logic                wordWrSel,
  input  logic [BSEL_W-1:0]   wordWrBank,
  input  logic [BANK_W-1:0]   wordWrData,
  input  logic [IDX_W-1:0]    testPin,
  input  logic [BSEL_W-1:0]   rdBank,
  input  logic [NUM_PINS-1:0] padIn,
  output logic                curEn,
  output logic                curOut,
  output logic                testBit,
  output logic [BANK_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] enAll,
  output logic [NUM_PINS-1:0] outAll
);
  localparam int IN_DEPTH = (WORD_IN_STAGES > TEST_STAGES) ? WORD_IN_STAGES : TEST_STAGES;

  logic [NUM_PINS-1:0] enReg, outReg, enNext, outNext;

  always_comb begin
    enNext  = enReg;
    outNext = outReg;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wordWrValid && int'(wordWrBank) == b) begin
        if (wordWrSel) outNext[b*BANK_W +: BANK_W] = wordWrData;
        else           enNext[b*BANK_W +: BANK_W]  = wordWrData;
      end
    end
    if (strobe.setEn)  enNext[strobe.pin]  = strobe.enVal;
    if (strobe.setOut) outNext[strobe.pin] = strobe.outVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      outReg <= '0;
    end else begin
      enReg  <= enNext;
      outReg <= outNext;
    end
  end

  logic [NUM_PINS-1:0] oePipe  [OUT_STAGES];
  logic [NUM_PINS-1:0] outPipe [OUT_STAGES];
  logic [NUM_PINS-1:0] inPipe  [IN_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < OUT_STAGES; s++) begin
        oePipe[s]  <= '0;
        outPipe[s] <= '0;
      end
      for (int s = 0; s < IN_DEPTH; s++) inPipe[s] <= '0;
    end else begin
      oePipe[0]  <= enReg;
      outPipe[0] <= outReg;
      for (int s = 1; s < OUT_STAGES; s++) begin
        oePipe[s]  <= oePipe[s-1];
        outPipe[s] <= outPipe[s-1];
      end
      inPipe[0] <= padIn;
      for (int s = 1; s < IN_DEPTH; s++) inPipe[s] <= inPipe[s-1];
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (int'(rdBank) == b) rdData = inPipe[WORD_IN_STAGES-1][b*BANK_W +: BANK_W];
  end

  assign testBit = inPipe[TEST_STAGES-1][testPin];
  assign curEn   = enReg[cmdPin];
  assign curOut  = outReg[cmdPin];
  assign padOe   = oePipe[OUT_STAGES-1];
  assign padOut  = outPipe[OUT_STAGES-1] & oePipe[OUT_STAGES-1];
  assign enAll   = enReg;
  assign outAll  = outReg;
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
  import gpio_pin_pkg::*;
#(
  parameter int          OUT_STAGES     = 3,
  parameter int          WORD_IN_STAGES = 3,
  parameter int          TEST_STAGES    = 2,
  parameter logic [31:0] LFSR_SEED      = 32'h1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [1:0]          cmdFamily,
  input  logic [2:0]          cmdSrc,
  input  logic [IDX_W-1:0]    cmdPin,
  input  logic                flagC,
  input  logic                flagZ,
  input  logic                wordWrValid,
  input  logic                wordWrSel,
  input  logic [BSEL_W-1:0]   wordWrBank,
  input  logic [BANK_W-1:0]   wordWrData,
  input  logic [BSEL_W-1:0]   rdBank,
  output logic [BANK_W-1:0]   rdData,
  input  logic                testValid,
  input  logic [IDX_W-1:0]    testPin,
  input  logic                testInvert,
  input  logic [2:0]          testOp,
  output logic                testCarryOut,
  output logic                testZeroOut,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut
);
  pinStrobeT           strobe;
  logic                curEn, curOut, testBit;
  logic [NUM_PINS-1:0] enAll, outAll;

  gpio_pin_ctrl #(.LFSR_SEED(LFSR_SEED)) uCtrl (
    .clk, .rstN, .cmdValid, .cmdFamily, .cmdSrc, .cmdPin, .flagC, .flagZ,
    .curEn, .curOut, .testValid, .testOp, .testInvert, .testBit,
    .strobe, .testCarryOut, .testZeroOut
  );

  gpio_pin_dp #(
    .OUT_STAGES(OUT_STAGES), .WORD_IN_STAGES(WORD_IN_STAGES), .TEST_STAGES(TEST_STAGES)
  ) uDp (
    .clk, .rstN, .strobe, .cmdPin, .wordWrValid, .wordWrSel, .wordWrBank, .wordWrData,
    .testPin, .rdBank, .padIn, .curEn, .curOut, .testBit, .rdData,
    .padOe, .padOut, .enAll, .outAll
  );
endmodule

// File: rtl/gpio_pin_checker.sv
module gpio_pin_checker
  import gpio_pin_pkg::*;
#(
  parameter int OUT_STAGES = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [1:0]          cmdFamily,
  input logic [IDX_W-1:0]    cmdPin,
  input logic                wordWrValid,
  input logic                testValid,
  input logic                flagC,
  input logic                flagZ,
  input logic                testCarryOut,
  input logic                testZeroOut,
  input logic [NUM_PINS-1:0] enAll,
  input logic [NUM_PINS-1:0] outAll,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut
);
  logic [1:0] aliveCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               aliveCnt <= '0;
    else if (aliveCnt != 2'd3) aliveCnt <= aliveCnt + 2'd1;
  end

  AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    aliveCnt == 2'd0 |-> (padOe == '0 && padOut == '0 && enAll == '0)); // R1

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0); // R7

  AST_FLT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdFamily == 2'd2 |=> !enAll[$past(cmdPin)]); // R3

  AST_DRV_SETS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdFamily == 2'd3 |=> enAll[$past(cmdPin)]); // R3

  AST_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !wordWrValid |=>
      ($countones(enAll ^ $past(enAll)) <= 1 && $countones(outAll ^ $past(outAll)) <= 1)); // R13

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !testValid |-> (testCarryOut == flagC && testZeroOut == flagZ)); // R10

  generate
    if (OUT_STAGES == 3) begin : gLat
      AST_OE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        aliveCnt == 2'd3 |-> (padOe == $past(enAll, 3))); // R6
    end
  endgenerate
endmodule

bind gpio_pin_unit gpio_pin_checker #(.OUT_STAGES(OUT_STAGES)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdFamily(cmdFamily), .cmdPin(cmdPin),
  .wordWrValid(wordWrValid), .testValid(testValid), .flagC(flagC), .flagZ(flagZ),
  .testCarryOut(testCarryOut), .testZeroOut(testZeroOut), .enAll(enAll), .outAll(outAll),
  .padOe(padOe), .padOut(padOut)
);

// File: tb/tb_gpio_pin_unit.sv
module tb_gpio_pin_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdFamily = '0;
  logic [2:0]  cmdSrc = '0;
  logic [5:0]  cmdPin = '0;
  logic        flagC = 1'b0, flagZ = 1'b0;
  logic        wordWrValid = 1'b0, wordWrSel = 1'b0;
  logic [0:0]  wordWrBank = '0;
  logic [31:0] wordWrData = '0;
  logic [0:0]  rdBank = '0;
  logic [31:0] rdData;
  logic        testValid = 1'b0, testInvert = 1'b0;
  logic [5:0]  testPin = '0;
  logic [2:0]  testOp = '0;
  logic        testCarryOut, testZeroOut;
  logic [63:0] padIn = '0;
  logic [63:0] padOe, padOut;

  int errors = 0;
  int checks = 0;
  logic [63:0] enM = '0, outM = '0;

  gpio_pin_unit dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic srcValue(input logic [2:0] src, input logic cur);
    case (src)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return flagC;
      3'd3: return ~flagC;
      3'd4: return flagZ;
      3'd5: return ~flagZ;
      default: return ~cur;
    endcase
  endfunction

  // One register update; checks the pads one clock early (old) and on time (new).
  task automatic step(input bit useCmd, input logic [1:0] fam, input logic [2:0] src,
                      input logic [5:0] pin, input bit useWord, input bit sel,
                      input bit bank, input logic [31:0] data, input string req);
    logic [63:0] oldEn, oldOut;
    logic v;
    oldEn = enM; oldOut = outM;
    if (useWord) begin
      if (sel) outM[bank*32 +: 32] = data;
      else     enM[bank*32 +: 32]  = data;
    end
    if (useCmd) begin
      v = srcValue(src, (fam == 2'd0) ? oldEn[pin] : oldOut[pin]);
      case (fam)
        2'd0: enM[pin] = v;
        2'd1: outM[pin] = v;
        2'd2: begin outM[pin] = v; enM[pin] = 1'b0; end
        default: begin outM[pin] = v; enM[pin] = 1'b1; end
      endcase
    end
    cmdValid = useCmd; cmdFamily = fam; cmdSrc = src; cmdPin = pin;
    wordWrValid = useWord; wordWrSel = sel; wordWrBank = bank; wordWrData = data;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; wordWrValid = 1'b0;
    repeat (2) @(negedge clk);
    check({req, " R6 early oe"}, padOe, oldEn);
    check({req, " R6 early out"}, padOut, oldOut & oldEn);
    @(negedge clk);
    check({req, " oe"}, padOe, enM);
    check({req, " out R7"}, padOut, outM & enM);
  endtask

  task automatic t_reset();
    check("R1 oe", padOe, '0);
    check("R1 out", padOut, '0);
    rdBank = 1'b0; #1;
    check("R1 rd0", {32'h0, rdData}, '0);
    rdBank = 1'b1; #1;
    check("R1 rd1", {32'h0, rdData}, '0);
  endtask

  task automatic t_families();
    step(1, 2'd3, 3'd1, 6'd5,  0, 0, 0, 0, "R3 drv hi pin5");
    step(1, 2'd0, 3'd1, 6'd40, 0, 0, 0, 0, "R2 R3 dir bankB");
    step(1, 2'd1, 3'd1, 6'd40, 0, 0, 0, 0, "R3 out pin40");
    step(1, 2'd2, 3'd0, 6'd40, 0, 0, 0, 0, "R3 flt pin40");
    step(1, 2'd1, 3'd1, 6'd41, 0, 0, 0, 0, "R7 out no drive");
    step(1, 2'd0, 3'd1, 6'd41, 0, 0, 0, 0, "R7 enable shows out");
    step(1, 2'd1, 3'd7, 6'd63, 0, 0, 0, 0, "R2 R13 not pin63");
  endtask

  task automatic t_sources();
    flagC = 1'b1; flagZ = 1'b0;
    step(1, 2'd3, 3'd2, 6'd8,  0, 0, 0, 0, "R4 src C");
    step(1, 2'd3, 3'd3, 6'd9,  0, 0, 0, 0, "R4 src NC");
    step(1, 2'd3, 3'd4, 6'd10, 0, 0, 0, 0, "R4 src Z");
    step(1, 2'd3, 3'd5, 6'd11, 0, 0, 0, 0, "R4 src NZ");
    flagC = 1'b0; flagZ = 1'b1;
    step(1, 2'd3, 3'd2, 6'd12, 0, 0, 0, 0, "R4 src C low");
    step(1, 2'd3, 3'd4, 6'd13, 0, 0, 0, 0, "R4 src Z high");
    step(1, 2'd0, 3'd7, 6'd12, 0, 0, 0, 0, "R4 dir invert");
    step(1, 2'd3, 3'd7, 6'd8,  0, 0, 0, 0, "R4 drv invert");
    flagC = 1'b0; flagZ = 1'b0;
  endtask

  task automatic t_random();
    int ones;
    ones = 0;
    for (int i = 0; i < 64; i++) begin
      cmdValid = 1'b1; cmdFamily = 2'd3; cmdSrc = 3'd6; cmdPin = 6'd20;
      @(posedge clk); @(negedge clk);
      cmdValid = 1'b0;
      repeat (3 + (i % 3)) @(negedge clk);
      if (padOut[20]) ones++;
    end
    enM[20] = 1'b1; outM[20] = padOut[20];
    check("R5 random has ones", 64'(ones > 0), 64'd1);
    check("R5 random has zeros", 64'(ones < 64), 64'd1);
  endtask

  task automatic t_word();
    step(0, 0, 0, 0, 1, 0, 1, 32'hA5A5_0F0F, "R11 word en bankB");
    step(0, 0, 0, 0, 1, 1, 1, 32'hFFFF_0000, "R11 word out bankB");
    step(1, 2'd1, 3'd0, 6'd7, 1, 1, 0, 32'hFFFF_FFFF, "R12 out vs word");
    step(1, 2'd0, 3'd1, 6'd3, 1, 0, 0, 32'h0000_0000, "R12 dir vs word");
    step(1, 2'd0, 3'd1, 6'd40, 1, 1, 1, 32'h1234_5678, "R12 diff regs");
  endtask

  task automatic t_inputs();
    logic b, f, r;
    testValid = 1'b1; testPin = 6'd34; testOp = 3'd0; testInvert = 1'b0;
    flagC = 1'b0; rdBank = 1'b1;
    padIn = 64'h0000_0004_8000_0001;
    @(posedge clk); @(negedge clk);
    check("R9 test early", {63'h0, testCarryOut}, 64'h0);
    @(posedge clk); @(negedge clk);
    check("R9 test fresh", {63'h0, testCarryOut}, 64'h1);
    check("R8 word early", {32'h0, rdData}, 64'h0);
    @(posedge clk); @(negedge clk);
    check("R8 word bankB", {32'h0, rdData}, 64'h4);
    rdBank = 1'b0; #1;
    check("R8 R2 word bankA", {32'h0, rdData}, 64'h8000_0001);
    for (int k = 0; k < 32; k++) begin
      testOp = k[2:0]; testInvert = k[3]; testPin = k[4] ? 6'd34 : 6'd1;
      flagC = k[0] ^ k[4]; flagZ = ~k[1];
      testPin = k[4] ? 6'd34 : 6'd2;
      #1;
      b = padIn[testPin] ^ testInvert;
      f = testOp[0] ? flagZ : flagC;
      case (testOp[2:1])
        2'd0: r = b;
        2'd1: r = f & b;
        2'd2: r = f | b;
        default: r = f ^ b;
      endcase
      check("R10 test op", {62'h0, testCarryOut, testZeroOut},
            {62'h0, testOp[0] ? flagC : r, testOp[0] ? r : flagZ});
    end
    testValid = 1'b0; flagC = 1'b1; flagZ = 1'b0; #1;
    check("R10 idle passthru", {62'h0, testCarryOut, testZeroOut}, 64'h2);
    flagC = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_families();
    t_sources();
    t_random();
    t_word();
    t_inputs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule